// File: doc/BRIEF.md
# Per-entry commit state tracker

This block sits beside a fetch target queue and follows, for every queue entry, which of its instruction slots the backend has reported as committed. Each entry holds up to `SLOTS` instructions. When an entry is written into the queue, the tracker records which slots carry a real instruction. From then on it collects per-slot commit notices, addressed by queue index and slot offset.

The tracker owns the release pointer of the queue, a wrap bit above an index. It looks only at the entry under that pointer. The entry is released when the commit notice for its last valid slot has arrived. It is also released when the backend's own commit position has already moved beyond it, because commit notices are not guaranteed for every instruction or every entry. A release is a one-cycle pulse that moves the pointer forward by one. A companion flag says whether the released entry may be used for predictor training.

An entry hit by a redirect that re-executes its own instruction, such as an exception or a replayed load, is still released, but with training withheld.

Top module: `commit_tracker`

## Requirements
- R1: After reset `comm_ptr` is 0 and `adv_pulse` and `adv_train` are 0.
- R2: Enqueueing an entry clears its commit state. An entry enqueued at the release pointer with a non-empty slot mask does not release in the following cycle unless the backend position is past it.
- R3: The last valid slot is the highest set bit of the enqueue mask. Commit notices for lower slots never release the entry. The notice for the last valid slot makes `adv_pulse` high in the cycle after the notice is taken.
- R4: Slots outside the mask count as already committed, so commit notices for them have no effect. An entry enqueued with an all-zero mask releases in the cycle after enqueue.
- R5: If `be_ptr` is strictly after `comm_ptr`, the occupied head entry releases in the same cycle, combinationally, with no commit notices needed. If `be_ptr` equals `comm_ptr`, the entry does not release.
- R6: Pointers are `{wrap, index}`. `a` is after `b` when the wrap bits are equal and the index of `a` is greater, or when the wrap bits differ and the index of `a` is smaller. `comm_ptr` counts through all 2*DEPTH values and wraps to 0.
- R7: A self-flush notice for an entry makes its later release have `adv_train` = 0. Re-enqueueing the entry clears this, so its next release trains (`adv_train` = 1).
- R8: At most one entry releases per cycle. `comm_ptr` increases by exactly one at each clock edge where `adv_pulse` is high, and stays unchanged otherwise.
- R9: An entry that has not been enqueued never releases, even when `be_ptr` is past it.
- R10: Commit notices for entries behind the head are kept. Completed entries therefore release on consecutive cycles, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue initialization strobe |
| enq_idx | input | IDX_W | Queue index being enqueued |
| enq_mask | input | SLOTS | Valid-slot mask of the new entry |
| cmt_valid | input | 1 | Commit notice strobe |
| cmt_idx | input | IDX_W | Queue index of the committed instruction |
| cmt_slot | input | SLOT_W | Slot offset of the committed instruction |
| flush_valid | input | 1 | Self-flush redirect strobe |
| flush_idx | input | IDX_W | Queue index hit by the self-flush |
| be_ptr | input | IDX_W+1 | Backend commit position, wrap bit on top |
| adv_pulse | output | 1 | Head entry releases this cycle |
| adv_train | output | 1 | Released entry may be used for training |
| comm_ptr | output | IDX_W+1 | Release pointer, wrap bit on top |

## Verification
The bench builds the block with DEPTH = 4 and SLOTS = 16. The small depth lets the release pointer run through both wrap values and return to zero within a short directed run. As a result, wrap-bit ordering against the backend position can be checked on both sides of a lap, including a backend position that looks numerically larger but is in fact behind. The full 16-slot width keeps the last-valid-slot detection meaningful: the bench uses masks whose highest bit is a middle slot, and masks that are all ones or all zeros.

// File: rtl/ctk_pkg.sv
package ctk_pkg;

   typedef struct packed {
      logic occ;
      logic flushed;
      logic last_done;
   } ent_stat_t;

   function automatic logic ptr_after(input logic wa, input logic wb,
                                      input logic gt, input logic lt);
      return (wa == wb) ? gt : lt;
   endfunction

endpackage

// File: rtl/ctk_last_slot.sv
module ctk_last_slot #(
   parameter int SLOTS  = 16,
   parameter int SLOT_W = $clog2(SLOTS)
) (
   input  logic [SLOTS-1:0]  mask,
   output logic [SLOT_W-1:0] last
);
   always_comb begin
      last = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (mask[i]) last = SLOT_W'(i);
      end
   end
endmodule

// File: rtl/ctk_ptr_order.sv
module ctk_ptr_order
   import ctk_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic [IDX_W:0] a,
   input  logic [IDX_W:0] b,
   output logic           a_after_b
);
   logic gt, lt;
   assign gt = a[IDX_W-1:0] > b[IDX_W-1:0];
   assign lt = a[IDX_W-1:0] < b[IDX_W-1:0];
   assign a_after_b = ptr_after(a[IDX_W], b[IDX_W], gt, lt);
endmodule

// File: rtl/ctk_entry.sv
module ctk_entry
   import ctk_pkg::*;
#(
   parameter int SLOTS  = 16,
   parameter int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_hit,
   input  logic [SLOTS-1:0]  enq_mask,
   input  logic              cmt_hit,
   input  logic [SLOT_W-1:0] cmt_slot,
   input  logic              flush_hit,
   input  logic              rel_hit,
   output ent_stat_t         stat
);
   logic              occ_q, flush_q;
   logic [SLOTS-1:0]  cbits_q;
   logic [SLOT_W-1:0] last_q, last_new;

   ctk_last_slot #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_last (
      .mask (enq_mask),
      .last (last_new)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q   <= 1'b0;
         flush_q <= 1'b0;
         cbits_q <= '0;
         last_q  <= '0;
      end else if (enq_hit) begin
         occ_q   <= 1'b1;
         flush_q <= 1'b0;
         cbits_q <= ~enq_mask;
         last_q  <= last_new;
      end else begin
         if (rel_hit)   occ_q   <= 1'b0;
         if (flush_hit) flush_q <= 1'b1;
         if (cmt_hit)   cbits_q[cmt_slot] <= 1'b1;
      end
   end

   assign stat.occ       = occ_q;
   assign stat.flushed   = flush_q;
   assign stat.last_done = cbits_q[last_q];
endmodule

// File: rtl/commit_tracker.sv
module commit_tracker
   import ctk_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int SLOTS = 16,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int PTR_W  = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [IDX_W-1:0]  enq_idx,
   input  logic [SLOTS-1:0]  enq_mask,
   input  logic              cmt_valid,
   input  logic [IDX_W-1:0]  cmt_idx,
   input  logic [SLOT_W-1:0] cmt_slot,
   input  logic              flush_valid,
   input  logic [IDX_W-1:0]  flush_idx,
   input  logic [PTR_W-1:0]  be_ptr,
   output logic              adv_pulse,
   output logic              adv_train,
   output logic [PTR_W-1:0]  comm_ptr
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("commit_tracker: DEPTH must be a power of two, at least 2");
   end
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("commit_tracker: SLOTS must be a power of two, at least 2");
   end

   logic [PTR_W-1:0] comm_q;
   logic [IDX_W-1:0] head;
   ent_stat_t        stat [DEPTH];
   ent_stat_t        head_stat;
   logic             be_past;

   assign head = comm_q[IDX_W-1:0];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      ctk_entry #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .enq_hit   (enq_valid   && (enq_idx   == IDX_W'(i))),
         .enq_mask  (enq_mask),
         .cmt_hit   (cmt_valid   && (cmt_idx   == IDX_W'(i))),
         .cmt_slot  (cmt_slot),
         .flush_hit (flush_valid && (flush_idx == IDX_W'(i))),
         .rel_hit   (adv_pulse   && (head      == IDX_W'(i))),
         .stat      (stat[i])
      );
   end

   ctk_ptr_order #(.IDX_W(IDX_W)) u_order (
      .a         (be_ptr),
      .b         (comm_q),
      .a_after_b (be_past)
   );

   assign head_stat = stat[head];
   assign adv_pulse = head_stat.occ && (head_stat.last_done || be_past);
   assign adv_train = adv_pulse && !head_stat.flushed;

   always_ff @(posedge clk) begin
      if (!rst_n)         comm_q <= '0;
      else if (adv_pulse) comm_q <= comm_q + PTR_W'(1);
   end

   assign comm_ptr = comm_q;
endmodule

// File: rtl/ctk_chk.sv
module ctk_chk #(
   parameter int IDX_W = 6,
   parameter int SLOTS = 16,
   localparam int PTR_W = IDX_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enq_valid,
   input logic [IDX_W-1:0] enq_idx,
   input logic [SLOTS-1:0] enq_mask,
   input logic             flush_valid,
   input logic [IDX_W-1:0] flush_idx,
   input logic [PTR_W-1:0] be_ptr,
   input logic             adv_pulse,
   input logic             adv_train,
   input logic [PTR_W-1:0] comm_ptr
);
   function automatic logic later(input logic [PTR_W-1:0] x, input logic [PTR_W-1:0] y);
      if (x[IDX_W] == y[IDX_W]) return x[IDX_W-1:0] > y[IDX_W-1:0];
      return x[IDX_W-1:0] < y[IDX_W-1:0];
   endfunction

   // R8
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_pulse |=> comm_ptr == PTR_W'($past(comm_ptr) + PTR_W'(1)));

   // R8
   hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_pulse |=> $stable(comm_ptr));

   // R7
   flush_notrain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid && flush_idx == comm_ptr[IDX_W-1:0] && !adv_pulse &&
       !(enq_valid && enq_idx == comm_ptr[IDX_W-1:0])) |=> !adv_train);

   // R2
   fresh_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && enq_idx == comm_ptr[IDX_W-1:0] && enq_mask != '0 && !adv_pulse)
      |=> (!adv_pulse || later(be_ptr, comm_ptr)));
endmodule

bind commit_tracker ctk_chk #(.IDX_W(IDX_W), .SLOTS(SLOTS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enq_valid   (enq_valid),
   .enq_idx     (enq_idx),
   .enq_mask    (enq_mask),
   .flush_valid (flush_valid),
   .flush_idx   (flush_idx),
   .be_ptr      (be_ptr),
   .adv_pulse   (adv_pulse),
   .adv_train   (adv_train),
   .comm_ptr    (comm_ptr)
);

// File: tb/sim_commit_tracker.sv
`timescale 1ns/1ps
module sim_commit_tracker;
   localparam int DEPTH = 4;
   localparam int SLOTS = 16;
   localparam int IDX_W = 2;
   localparam int SLOT_W = 4;
   localparam int PTR_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enq_valid = 1'b0;
   logic [IDX_W-1:0] enq_idx = '0;
   logic [SLOTS-1:0] enq_mask = '0;
   logic cmt_valid = 1'b0;
   logic [IDX_W-1:0] cmt_idx = '0;
   logic [SLOT_W-1:0] cmt_slot = '0;
   logic flush_valid = 1'b0;
   logic [IDX_W-1:0] flush_idx = '0;
   logic [PTR_W-1:0] be_ptr = '0;
   logic adv_pulse, adv_train;
   logic [PTR_W-1:0] comm_ptr;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   commit_tracker #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u0 (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_idx(enq_idx), .enq_mask(enq_mask),
      .cmt_valid(cmt_valid), .cmt_idx(cmt_idx), .cmt_slot(cmt_slot),
      .flush_valid(flush_valid), .flush_idx(flush_idx), .be_ptr(be_ptr),
      .adv_pulse(adv_pulse), .adv_train(adv_train), .comm_ptr(comm_ptr)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
      enq_valid = 1'b0; cmt_valid = 1'b0; flush_valid = 1'b0;
      #1;
   endtask

   task automatic do_enq(input int idx, input logic [SLOTS-1:0] m);
      enq_valid = 1'b1; enq_idx = IDX_W'(idx); enq_mask = m;
      tick();
   endtask

   task automatic do_cmt(input int idx, input int slot);
      cmt_valid = 1'b1; cmt_idx = IDX_W'(idx); cmt_slot = SLOT_W'(slot);
      tick();
   endtask

   task automatic do_flush(input int idx);
      flush_valid = 1'b1; flush_idx = IDX_W'(idx);
      tick();
   endtask

   task automatic t_reset();
      rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; #1;
      chk("R1 comm_ptr", int'(comm_ptr), 0);
      chk("R1 adv_pulse", int'(adv_pulse), 0);
      chk("R1 adv_train", int'(adv_train), 0);
   endtask

   task automatic t_empty_queue();
      be_ptr = 3'd1; #1;
      chk("R9 no release of empty entry", int'(adv_pulse), 0);
      tick(); tick();
      chk("R9 pointer held", int'(comm_ptr), 0);
      be_ptr = 3'd0; #1;
   endtask

   task automatic t_last_slot();
      do_enq(0, 16'h00FF);
      chk("R2 fresh entry not released", int'(adv_pulse), 0);
      for (int s = 0; s < 7; s++) begin
         do_cmt(0, s);
         chk("R3 lower slot no release", int'(adv_pulse), 0);
      end
      do_cmt(0, 9);
      chk("R4 outside-mask notice ignored", int'(adv_pulse), 0);
      do_cmt(0, 7);
      chk("R3 last slot releases", int'(adv_pulse), 1);
      chk("R3 release trains", int'(adv_train), 1);
      tick();
      chk("R8 pointer +1", int'(comm_ptr), 1);
      chk("R8 single release", int'(adv_pulse), 0);
      be_ptr = 3'd1;
   endtask

   task automatic t_empty_mask();
      do_enq(1, 16'h0000);
      chk("R4 empty mask releases", int'(adv_pulse), 1);
      chk("R4 empty mask trains", int'(adv_train), 1);
      tick();
      chk("R4 pointer after empty mask", int'(comm_ptr), 2);
      be_ptr = 3'd2;
   endtask

   task automatic t_backend_past();
      do_enq(2, 16'hFFFF);
      chk("R5 equal position no release", int'(adv_pulse), 0);
      be_ptr = 3'd3; #1;
      chk("R5 backend past releases", int'(adv_pulse), 1);
      tick();
      chk("R5 pointer after past release", int'(comm_ptr), 3);
      be_ptr = 3'd3;
   endtask

   task automatic t_flush();
      do_enq(3, 16'h0001);
      do_flush(3);
      chk("R7 flushed not yet released", int'(adv_pulse), 0);
      do_cmt(3, 0);
      chk("R7 flushed entry releases", int'(adv_pulse), 1);
      chk("R7 flushed entry no train", int'(adv_train), 0);
      tick();
      chk("R6 pointer enters wrap lap", int'(comm_ptr), 4);
      be_ptr = 3'd4;
   endtask

   task automatic t_back_to_back();
      do_enq(0, 16'h0003);
      do_enq(1, 16'h0001);
      do_cmt(1, 0);
      chk("R10 non-head commit no release", int'(adv_pulse), 0);
      do_cmt(0, 1);
      chk("R10 head releases", int'(adv_pulse), 1);
      tick();
      chk("R10 pointer after first", int'(comm_ptr), 5);
      chk("R10 kept commit releases next cycle", int'(adv_pulse), 1);
      chk("R10 second release trains", int'(adv_train), 1);
      tick();
      chk("R10 pointer after second", int'(comm_ptr), 6);
      chk("R10 no third release", int'(adv_pulse), 0);
      be_ptr = 3'd6;
   endtask

   task automatic t_flush_cleared();
      do_enq(2, 16'h0000);
      tick();
      be_ptr = 3'd7;
      do_enq(3, 16'h0000);
      chk("R7 re-enqueue release", int'(adv_pulse), 1);
      chk("R7 re-enqueue clears flush", int'(adv_train), 1);
      tick();
      chk("R6 pointer wraps to 0", int'(comm_ptr), 0);
   endtask

   task automatic t_wrap_order();
      be_ptr = 3'd0;
      do_enq(0, 16'hFFFF);
      be_ptr = 3'd7; #1;
      chk("R6 previous lap not past", int'(adv_pulse), 0);
      be_ptr = 3'd1; #1;
      chk("R6 same lap ahead is past", int'(adv_pulse), 1);
      tick();
      chk("R6 pointer after wrap release", int'(comm_ptr), 1);
   endtask

   initial begin
      #1;
      t_reset();
      t_empty_queue();
      t_last_slot();
      t_empty_mask();
      t_backend_past();
      t_flush();
      t_back_to_back();
      t_flush_cleared();
      t_wrap_order();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule